// File: doc/BRIEF.md
# Mailbox Command Frame Writer

This block turns a request for a satellite dish control message, or for a tone switch, into a series of 16-bit writes into a shared mailbox window. The mailbox is read by firmware on another processor. A message request carries a byte buffer, a byte count and a burst selection. The block builds an 18-word command frame from them and writes it out one word at a time over a plain write port that has an address, data and a one-cycle strobe. A tone request writes a two-word frame instead.

The firmware treats the header word as the doorbell, so the write order matters. The payload words go out first, in ascending order. The length word follows, and the header word at the base of the window goes last. A programmable idle gap follows every single write. A one-cycle done pulse marks the end of the gap after the header write, and only then does the block accept new work.

Top module: `mbox_cmd_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_stb` and `done` are all 0.
- R2: A message byte count above `MAX_MSG` (default 10) is treated as `MAX_MSG`, both in the frame fields and in how many payload bytes are copied.
- R3: In a message frame, word 1 holds the clamped count plus 2 and word 2 holds the clamped count.
- R4: Word 3 holds the burst field, selected by `burst_sel`: 0 gives 16'h0000, 1 gives 16'h0001, and 2 or 3 give 16'hFFFF (no burst).
- R5: Words 4 to 17 hold payload byte k (bits [8k+7:8k] of `msg_bytes`) zero-extended in word 4+k when k is below the clamped count. Every other word up to 17 is 16'h0000.
- R6: Word i is written to address `BASE_ADDR + 2*i`. A message frame writes words 2 to 17 in ascending order, then word 1, then word 0, for 18 writes in all.
- R7: Word 0 is `{CMD_CLASS, op}`, with op equal to `OP_SEND` for a message. It is always the last write of a frame.
- R8: Each write is a one-cycle strobe. Successive strobes of one frame are exactly `GAP_CYCLES+1` cycles apart.
- R9: A tone request writes exactly two words: 16'h0000 at `BASE_ADDR+2`, then `{CMD_CLASS, tone_on ? OP_TONE_ON : OP_TONE_OFF}` at `BASE_ADDR`.
- R10: `done` pulses for one cycle, `GAP_CYCLES+1` cycles after the last strobe. `busy` is high from the cycle after the start until `done`, and no strobe occurs while `busy` is low.
- R11: Start requests that arrive while `busy` is high are ignored. If `msg_start` and `tone_start` arrive together while idle, the message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_start | input | 1 | Request to send a message frame |
| msg_len | input | 8 | Message byte count (clamped to MAX_MSG) |
| msg_bytes | input | 8*MAX_MSG | Message bytes; byte k at bits [8k+7:8k] |
| burst_sel | input | 2 | 0 = burst A, 1 = burst B, 2/3 = no burst |
| tone_start | input | 1 | Request to send a tone frame |
| tone_on | input | 1 | Tone frame selects on (1) or off (0) |
| wr_addr | output | ADDR_W | Mailbox byte address of the current write |
| wr_data | output | 16 | Mailbox data of the current write |
| wr_stb | output | 1 | One-cycle write strobe |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the final gap |

## Verification
The bench builds the block with `GAP_CYCLES` = 3 and `BASE_ADDR` = 16'h0400. The short gap lets a whole 18-word frame finish in under 80 cycles, so strobe spacing and the position of the done pulse can be checked write by write. The non-zero base address shows that the word index is doubled onto an offset rather than used as an address on its own. The remaining defaults (ten-byte limit, 18-word frame) are kept, so the length clamp and the zero-filled tail beyond the payload both get exercised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
    parameter int GAP_CYCLES = 3,
    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CNT_W'(GAP_CYCLES - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = tmr_q.run && (tmr_q.cnt == '0);
endmodule

// File: rtl/mbox_frame_word.sv
module mbox_frame_word #(
    parameter int         MAX_MSG     = 10,
    parameter logic [7:0] CMD_CLASS   = 8'h05,
    parameter logic [7:0] OP_SEND     = 8'h12,
    parameter logic [7:0] OP_TONE_ON  = 8'h01,
    parameter logic [7:0] OP_TONE_OFF = 8'h00,
    localparam int LEN_W = $clog2(MAX_MSG + 1)
) (
    input  logic [4:0]           word_idx,
    input  logic                 tone_mode,
    input  logic                 tone_on,
    input  logic [LEN_W-1:0]     len,
    input  logic [1:0]           burst,
    input  logic [8*MAX_MSG-1:0] bytes,
    output logic [15:0]          word
);
    always_comb begin
        word = 16'h0000;
        if (word_idx == 5'd0) begin
            if (tone_mode) word = {CMD_CLASS, tone_on ? OP_TONE_ON : OP_TONE_OFF};
            else           word = {CMD_CLASS, OP_SEND};
        end else if (!tone_mode) begin
            if (word_idx == 5'd1) begin
                word = 16'(len) + 16'd2;
            end else if (word_idx == 5'd2) begin
                word = 16'(len);
            end else if (word_idx == 5'd3) begin
                case (burst)
                    2'd0:    word = 16'h0000;
                    2'd1:    word = 16'h0001;
                    default: word = 16'hFFFF;
                endcase
            end else begin
                for (int i = 0; i < MAX_MSG; i++) begin
                    if ((int'(word_idx) == i + 4) && (i < int'(len)))
                        word = {8'h00, bytes[i*8 +: 8]};
                end
            end
        end
    end
endmodule

// File: rtl/mbox_cmd_writer.sv
module mbox_cmd_writer
    import mbox_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] BASE_ADDR   = 16'h0400,
    parameter int          GAP_CYCLES  = 3,
    parameter int          MAX_MSG     = 10,
    parameter logic [7:0]  CMD_CLASS   = 8'h05,
    parameter logic [7:0]  OP_SEND     = 8'h12,
    parameter logic [7:0]  OP_TONE_ON  = 8'h01,
    parameter logic [7:0]  OP_TONE_OFF = 8'h00,
    localparam int FRAME_WORDS = 18,
    localparam int TONE_WORDS  = 2,
    localparam int SLOT_W      = $clog2(FRAME_WORDS),
    localparam int LEN_W       = $clog2(MAX_MSG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_start,
    input  logic [7:0]           msg_len,
    input  logic [8*MAX_MSG-1:0] msg_bytes,
    input  logic [1:0]           burst_sel,
    input  logic                 tone_start,
    input  logic                 tone_on,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [15:0]          wr_data,
    output logic                 wr_stb,
    output logic                 busy,
    output logic                 done
);
    typedef struct packed {
        seq_state_e           state;
        logic [SLOT_W-1:0]    slot;
        logic [SLOT_W-1:0]    last;
        logic                 tone_mode;
        logic                 tone_on;
        logic [LEN_W-1:0]     len;
        logic [1:0]           burst;
        logic [8*MAX_MSG-1:0] bytes;
        logic                 done;
    } seq_t;

    seq_t s_d, s_q;
    logic gap_load, gap_expired;
    logic [4:0] word_idx;
    logic [15:0] word;
    logic [LEN_W-1:0] len_clamped;

    assign len_clamped = (int'(msg_len) > MAX_MSG) ? LEN_W'(MAX_MSG) : msg_len[LEN_W-1:0];

    // slot order: payload words ascending, then length word, header last
    always_comb begin
        if (s_q.slot == s_q.last)                word_idx = 5'd0;
        else if (s_q.slot == s_q.last - 1'b1)    word_idx = 5'd1;
        else                                     word_idx = 5'(s_q.slot) + 5'd2;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        gap_load = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (msg_start) begin
                    s_d.state     = ST_WR;
                    s_d.slot      = '0;
                    s_d.last      = SLOT_W'(FRAME_WORDS - 1);
                    s_d.tone_mode = 1'b0;
                    s_d.len       = len_clamped;
                    s_d.burst     = burst_sel;
                    s_d.bytes     = msg_bytes;
                end else if (tone_start) begin
                    s_d.state     = ST_WR;
                    s_d.slot      = '0;
                    s_d.last      = SLOT_W'(TONE_WORDS - 1);
                    s_d.tone_mode = 1'b1;
                    s_d.tone_on   = tone_on;
                end
            end
            ST_WR: begin
                gap_load  = 1'b1;
                s_d.state = ST_GAP;
            end
            ST_GAP: begin
                if (gap_expired) begin
                    if (s_q.slot == s_q.last) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.state = ST_WR;
                        s_d.slot  = s_q.slot + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mbox_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    mbox_frame_word #(
        .MAX_MSG    (MAX_MSG),
        .CMD_CLASS  (CMD_CLASS),
        .OP_SEND    (OP_SEND),
        .OP_TONE_ON (OP_TONE_ON),
        .OP_TONE_OFF(OP_TONE_OFF)
    ) u_word (
        .word_idx (word_idx),
        .tone_mode(s_q.tone_mode),
        .tone_on  (s_q.tone_on),
        .len      (s_q.len),
        .burst    (s_q.burst),
        .bytes    (s_q.bytes),
        .word     (word)
    );

    assign wr_stb  = (s_q.state == ST_WR);
    assign wr_addr = ADDR_W'(BASE_ADDR) + ADDR_W'({word_idx, 1'b0});
    assign wr_data = word;
    assign busy    = (s_q.state != ST_IDLE);
    assign done    = s_q.done;
endmodule

// File: rtl/mbox_cmd_checker.sv
module mbox_cmd_checker #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_ADDR  = 16'h0400,
    parameter int          GAP_CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_start,
    input logic              tone_start,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_stb,
    input logic              busy,
    input logic              done
);
    logic        seen_q;
    logic [31:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (done) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (wr_stb) begin
            seen_q  <= 1'b1;
            since_q <= '0;
        end else begin
            since_q <= since_q + 1;
        end
    end

    assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_stb_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && seen_q) |-> (since_q == 32'(GAP_CYCLES)));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_no_stb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_stb);
    assert_addr_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr[0] == 1'b0 && wr_addr >= ADDR_W'(BASE_ADDR)));
    assert_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && (msg_start || tone_start) && !$past(done)) |=> (busy || done));
endmodule

bind mbox_cmd_writer mbox_cmd_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .GAP_CYCLES(GAP_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_start (msg_start),
    .tone_start(tone_start),
    .wr_addr   (wr_addr),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_mbox_cmd_writer.sv
module sim_mbox_cmd_writer;
    localparam int          GAP   = 3;
    localparam logic [15:0] BASE  = 16'h0400;
    localparam int          MAXM  = 10;
    localparam logic [7:0]  CLS   = 8'h05;
    localparam logic [7:0]  OPS   = 8'h12;
    localparam logic [7:0]  OPON  = 8'h01;
    localparam logic [7:0]  OPOFF = 8'h00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_start = 1'b0;
    logic [7:0] msg_len = '0;
    logic [8*MAXM-1:0] msg_bytes = '0;
    logic [1:0] burst_sel = '0;
    logic tone_start = 1'b0;
    logic tone_on = 1'b0;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic wr_stb, busy, done;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mbox_cmd_writer #(
        .ADDR_W(16), .BASE_ADDR(BASE), .GAP_CYCLES(GAP), .MAX_MSG(MAXM),
        .CMD_CLASS(CLS), .OP_SEND(OPS), .OP_TONE_ON(OPON), .OP_TONE_OFF(OPOFF)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_len(msg_len),
        .msg_bytes(msg_bytes), .burst_sel(burst_sel), .tone_start(tone_start),
        .tone_on(tone_on), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [15:0] exp_addr [18];
    logic [15:0] exp_data [18];
    int exp_n;

    task automatic build_expect(input bit is_tone, input bit ton, input int len,
                                input logic [8*MAXM-1:0] b, input logic [1:0] bs);
        logic [15:0] w [18];
        int l;
        if (is_tone) begin
            exp_n = 2;
            exp_addr[0] = BASE + 16'd2; exp_data[0] = 16'h0000;
            exp_addr[1] = BASE;         exp_data[1] = {CLS, ton ? OPON : OPOFF};
        end else begin
            l = (len > MAXM) ? MAXM : len;
            w[0] = {CLS, OPS};
            w[1] = 16'(l + 2);
            w[2] = 16'(l);
            w[3] = (bs == 2'd0) ? 16'h0000 : (bs == 2'd1) ? 16'h0001 : 16'hFFFF;
            for (int k = 0; k < 14; k++)
                w[4+k] = (k < l) ? {8'h00, b[k*8 +: 8]} : 16'h0000;
            exp_n = 18;
            for (int s = 0; s < 16; s++) begin
                exp_addr[s] = BASE + 16'(2*(s+2));
                exp_data[s] = w[s+2];
            end
            exp_addr[16] = BASE + 16'd2; exp_data[16] = w[1];
            exp_addr[17] = BASE;         exp_data[17] = w[0];
        end
    endtask

    // Runs one frame; req tags the content requirement under test.
    task automatic run_job(input string req, input bit is_tone, input bit ton,
                           input int len, input logic [8*MAXM-1:0] b,
                           input logic [1:0] bs, input bit both, input bit inject);
        int cyc = 0, nstb = 0, last = 0;
        bit got_done = 0;
        build_expect(is_tone, ton, len, b, bs);
        @(negedge clk);
        msg_len = 8'(len); msg_bytes = b; burst_sel = bs; tone_on = ton;
        msg_start  = !is_tone || both;
        tone_start = is_tone || both;
        while (!got_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            msg_start = 1'b0;
            tone_start = 1'b0;
            if (inject && (cyc == 6 || cyc == 20)) begin
                msg_start = 1'b1; tone_start = 1'b1; msg_len = 8'd1; tone_on = 1'b1;
            end
            if (cyc == 1) chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 1);
            if (wr_stb) begin
                if (nstb < exp_n) begin
                    chk(wr_addr === exp_addr[nstb], "R6", $sformatf("%s addr of write %0d", req, nstb),
                        32'(wr_addr), 32'(exp_addr[nstb]));
                    chk(wr_data === exp_data[nstb], req, $sformatf("data of write %0d", nstb),
                        32'(wr_data), 32'(exp_data[nstb]));
                end
                if (nstb > 0)
                    chk(cyc - last == GAP + 1, "R8", "strobe spacing", 32'(cyc - last), GAP + 1);
                last = cyc;
                nstb++;
            end
            if (done) begin
                got_done = 1;
                chk(cyc - last == GAP + 1, "R10", "done delay", 32'(cyc - last), GAP + 1);
                chk(busy === 1'b0, "R10", "idle with done", 32'(busy), 0);
            end
        end
        chk(got_done, "R10", "done seen", 32'(got_done), 1);
        chk(nstb == exp_n, is_tone ? "R9" : "R6", "write count", 32'(nstb), 32'(exp_n));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!wr_stb && !done && !busy, "R11", "quiet after frame",
                {29'd0, wr_stb, done, busy}, 0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(busy === 1'b0 && wr_stb === 1'b0 && done === 1'b0, "R1", "reset state",
            {29'd0, busy, wr_stb, done}, 0);
    endtask

    logic [8*MAXM-1:0] pat;

    initial begin
        for (int i = 0; i < MAXM; i++) pat[i*8 +: 8] = 8'hA1 + 8'(i * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_job("R5", 0, 0, 3, pat, 2'd0, 0, 0);   // short payload, burst A
        run_job("R4", 0, 0, 10, pat, 2'd1, 0, 0);  // full payload, burst B
        run_job("R2", 0, 0, 14, pat, 2'd2, 0, 0);  // clamp, no burst
        run_job("R3", 0, 0, 0, pat, 2'd3, 0, 0);   // empty payload
        run_job("R9", 1, 1, 0, pat, 2'd0, 0, 0);   // tone on
        run_job("R9", 1, 0, 0, pat, 2'd0, 0, 0);   // tone off
        run_job("R11", 0, 0, 5, pat, 2'd1, 1, 0);  // both starts: message wins
        run_job("R11", 0, 0, 7, pat, 2'd0, 0, 1);  // starts during busy ignored
        run_job("R7", 1, 1, 0, pat, 2'd0, 0, 1);   // tone with injected starts
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule